// File: doc/BRIEF.md
# Configurable Coarse-Grained Processing Element

This block is one compute tile of a coarse-grained overlay array. Its router hands it a 96-bit configuration word. The word holds two immediate operands, one source select for each operand, an ALU opcode, four result-destination slots, a result action code and a repeat flag. Once a word is armed, the element waits until every operand source it selected holds valid data. It then takes those operands and computes one of eight functions. The result goes to neighbour links, to the router port and/or to the final-result output.

Single-cycle functions return their result one clock after the operands are taken. Division runs as a bit-serial restoring divider. While it runs, the element reports busy, takes no operands and refuses new configuration. A configuration with the repeat flag set re-fires every time fresh operands arrive, until another word replaces it. Without the flag it fires once.

Top module: `coarse_pe`

## Requirements
- R1: A configuration word is accepted (`cfg_valid` and `cfg_ready` both high at a clock edge) only while no division is running. `cfg_ready` is low while the divider runs, and a word offered then is dropped. An accepted word replaces the whole active word at once, and the element never fires in the cycle a word is accepted.
- R2: Operand selects sit at bits 63:60 (operand A) and 59:56 (operand B). Code 0 takes the immediate: A from bits 95:80, B from bits 79:64. Codes 1 to 4 take neighbour link 0 to 3. Code 5 takes the router input. Any other code behaves like code 0.
- R3: The opcode sits at bits 55:52. The codes are 0 add, 1 subtract, 2 multiply, 3 divide, 4 no-operation (passes A), 5 AND, 6 OR, 7 XOR. Codes 8 to 15 act as no-operation. Arithmetic results are taken modulo 2^16.
- R4: For every opcode other than divide, the result is presented in the clock cycle right after the edge at which the operands were taken.
- R5: A divide presents the quotient 16 cycles after the edge at which the operands were taken. `busy` is high until then, no operand is taken meanwhile, and division by zero yields 0xFFFF.
- R6: The element fires only when every selected neighbour or router source has its valid bit high. In the firing cycle it pulses `nbr_in_take` for each neighbour link it reads and `rtr_in_take` if it reads the router.
- R7: The action code sits at bits 11:8. Code 0 sends the result to the final-result output only and ignores the slots. Code 1 steers the result through the destination slots. Any other code discards the result.
- R8: Bits 51:12 hold four 10-bit slots, slot i at bits 12+10i+9 down to 12+10i. In each slot, bit 9 is valid, bits 8:7 are the kind (0 neighbour, 1 router, 2 final, 3 ignored) and bits 6:0 are the target. Every valid slot gets the same result. A neighbour slot drives the link named by its target, and a target of 4 or above drives nothing. When several router slots are valid, the lowest-numbered one supplies `rtr_out_target`.
- R9: When bit 7 is set, the armed word fires again each time its operands are ready, until it is reconfigured. When bit 7 is clear, it fires once and then stays quiet.
- R10: After reset nothing is armed, all output valids and `busy` are low, and `cfg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_word | input | 96 | Configuration word |
| cfg_ready | output | 1 | Element can accept a configuration word |
| nbr_in_data | input | 64 | Four 16-bit neighbour link inputs, link n at bits 16n+15:16n |
| nbr_in_valid | input | 4 | Valid per neighbour link input |
| nbr_in_take | output | 4 | Neighbour link input consumed this cycle |
| rtr_in_data | input | 16 | Operand from the router |
| rtr_in_valid | input | 1 | Router operand valid |
| rtr_in_take | output | 1 | Router operand consumed this cycle |
| busy | output | 1 | Divider running |
| nbr_out_data | output | 16 | Result toward neighbours |
| nbr_out_valid | output | 4 | Result valid per neighbour link |
| rtr_out_data | output | 16 | Result toward the router |
| rtr_out_valid | output | 1 | Router result valid |
| rtr_out_target | output | 7 | Target carried with the router result |
| fin_data | output | 16 | Final result |
| fin_valid | output | 1 | Final result valid |

## Verification
The hardest case to reach from the ports is a configuration word that arrives while a division is still in flight. The word is not stored anywhere that can be seen, so dropping it leaves no direct trace. The bench starts a divide and offers a repeating word while `busy` is high. That word would fire every cycle if it were taken. The bench then checks that only the quotient comes out and that the final-result output stays silent afterwards. Destination priority is reached with a word that names two router slots and a neighbour slot at the same time.

// File: rtl/coarse_pe_pkg.sv
package coarse_pe_pkg;

   localparam int CFG_W  = 96;
   localparam int IMM_W  = 16;
   localparam int SEL_W  = 4;
   localparam int OPC_W  = 4;
   localparam int ACT_W  = 4;
   localparam int NSLOT  = 4;
   localparam int SLOT_W = 10;
   localparam int DST_W  = NSLOT * SLOT_W;
   localparam int KIND_W = 2;
   localparam int TGT_W  = 7;

   // field layout, most significant field first
   typedef struct packed {
      logic [IMM_W-1:0] imm_a;
      logic [IMM_W-1:0] imm_b;
      logic [SEL_W-1:0] sel_a;
      logic [SEL_W-1:0] sel_b;
      logic [OPC_W-1:0] opc;
      logic [DST_W-1:0] dst;
      logic [ACT_W-1:0] act;
      logic             rpt;
      logic [6:0]       rsvd;
   } cfg_t;

   localparam logic [OPC_W-1:0] OPC_ADD = 4'd0;
   localparam logic [OPC_W-1:0] OPC_SUB = 4'd1;
   localparam logic [OPC_W-1:0] OPC_MUL = 4'd2;
   localparam logic [OPC_W-1:0] OPC_DIV = 4'd3;
   localparam logic [OPC_W-1:0] OPC_NOP = 4'd4;
   localparam logic [OPC_W-1:0] OPC_AND = 4'd5;
   localparam logic [OPC_W-1:0] OPC_OR  = 4'd6;
   localparam logic [OPC_W-1:0] OPC_XOR = 4'd7;

   localparam logic [ACT_W-1:0] ACT_FINAL = 4'd0;
   localparam logic [ACT_W-1:0] ACT_STEER = 4'd1;

   localparam logic [KIND_W-1:0] KIND_NBR = 2'd0;
   localparam logic [KIND_W-1:0] KIND_RTR = 2'd1;
   localparam logic [KIND_W-1:0] KIND_FIN = 2'd2;

endpackage

// File: rtl/coarse_pe_cfg_reg.sv
module coarse_pe_cfg_reg
   import coarse_pe_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  cfg_t word_in,
   input  logic fire,
   output cfg_t word_q,
   output logic armed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         armed  <= 1'b0;
      end else if (load) begin
         word_q <= word_in;
         armed  <= 1'b1;
      end else if (fire && !word_q.rpt) begin
         armed  <= 1'b0;
      end
   end

endmodule

// File: rtl/coarse_pe_opnd_mux.sv
module coarse_pe_opnd_mux
   import coarse_pe_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NBR_N  = 4
) (
   input  logic [SEL_W-1:0]        sel,
   input  logic [DATA_W-1:0]       imm,
   input  logic [NBR_N*DATA_W-1:0] nbr_data,
   input  logic [NBR_N-1:0]        nbr_valid,
   input  logic [DATA_W-1:0]       rtr_data,
   input  logic                    rtr_valid,
   output logic [DATA_W-1:0]       opnd,
   output logic                    ready,
   output logic [NBR_N-1:0]        nbr_need,
   output logic                    rtr_need
);

   localparam logic [SEL_W-1:0] RTR_CODE = SEL_W'(NBR_N + 1);

   always_comb begin
      opnd     = imm;
      ready    = 1'b1;
      nbr_need = '0;
      rtr_need = 1'b0;
      for (int n = 0; n < NBR_N; n++) begin
         if (sel == SEL_W'(n + 1)) begin
            opnd        = nbr_data[n*DATA_W +: DATA_W];
            ready       = nbr_valid[n];
            nbr_need[n] = 1'b1;
         end
      end
      if (sel == RTR_CODE) begin
         opnd     = rtr_data;
         ready    = rtr_valid;
         rtr_need = 1'b1;
      end
   end

endmodule

// File: rtl/coarse_pe_alu.sv
module coarse_pe_alu
   import coarse_pe_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OPC_W-1:0]  opc,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam int PRD_W = 2 * DATA_W;

   logic [DATA_W-1:0] rem_q, quo_q, den_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PRD_W-1:0]  prod;
   logic [DATA_W-1:0] quick;
   logic [DATA_W:0]   trial;
   logic              fits;
   logic [DATA_W-1:0] rem_nx, quo_nx;

   always_comb begin
      prod = PRD_W'(a) * PRD_W'(b);
      case (opc)
         OPC_ADD: quick = a + b;
         OPC_SUB: quick = a - b;
         OPC_MUL: quick = prod[DATA_W-1:0];
         OPC_AND: quick = a & b;
         OPC_OR:  quick = a | b;
         OPC_XOR: quick = a ^ b;
         default: quick = a;
      endcase
   end

   // one restoring step per cycle
   always_comb begin
      trial  = {rem_q, quo_q[DATA_W-1]};
      fits   = (trial >= {1'b0, den_q});
      rem_nx = fits ? DATA_W'(trial - {1'b0, den_q}) : trial[DATA_W-1:0];
      quo_nx = {quo_q[DATA_W-2:0], fits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         result <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy   <= 1'b0;
               done   <= 1'b1;
               result <= quo_nx;
            end
         end else if (start) begin
            if (opc == OPC_DIV) begin
               busy  <= 1'b1;
               rem_q <= '0;
               quo_q <= a;
               den_q <= b;
               cnt_q <= CNT_W'(DATA_W);
            end else begin
               result <= quick;
               done   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/coarse_pe_steer.sv
module coarse_pe_steer
   import coarse_pe_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NBR_N  = 4
) (
   input  logic              done,
   input  logic [DATA_W-1:0] result,
   input  logic [ACT_W-1:0]  act,
   input  logic [DST_W-1:0]  dst,
   output logic [DATA_W-1:0] nbr_out_data,
   output logic [NBR_N-1:0]  nbr_out_valid,
   output logic [DATA_W-1:0] rtr_out_data,
   output logic              rtr_out_valid,
   output logic [TGT_W-1:0]  rtr_out_target,
   output logic [DATA_W-1:0] fin_data,
   output logic              fin_valid
);

   logic              slot_v    [NSLOT];
   logic [KIND_W-1:0] slot_kind [NSLOT];
   logic [TGT_W-1:0]  slot_tgt  [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_v[s]    = dst[s*SLOT_W + SLOT_W - 1];
      assign slot_kind[s] = dst[s*SLOT_W + TGT_W +: KIND_W];
      assign slot_tgt[s]  = dst[s*SLOT_W +: TGT_W];
   end

   logic steer;
   assign steer        = done && (act == ACT_STEER);
   assign nbr_out_data = result;
   assign rtr_out_data = result;
   assign fin_data     = result;

   always_comb begin
      nbr_out_valid  = '0;
      rtr_out_valid  = 1'b0;
      rtr_out_target = '0;
      fin_valid      = done && (act == ACT_FINAL);
      // walk downward so the lowest router slot supplies the target
      for (int s = NSLOT - 1; s >= 0; s--) begin
         if (steer && slot_v[s]) begin
            case (slot_kind[s])
               KIND_NBR: begin
                  for (int n = 0; n < NBR_N; n++) begin
                     if (slot_tgt[s] == TGT_W'(n)) nbr_out_valid[n] = 1'b1;
                  end
               end
               KIND_RTR: begin
                  rtr_out_valid  = 1'b1;
                  rtr_out_target = slot_tgt[s];
               end
               KIND_FIN: fin_valid = 1'b1;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/coarse_pe.sv
module coarse_pe
   import coarse_pe_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NBR_N  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_valid,
   input  logic [CFG_W-1:0]        cfg_word,
   output logic                    cfg_ready,
   input  logic [NBR_N*DATA_W-1:0] nbr_in_data,
   input  logic [NBR_N-1:0]        nbr_in_valid,
   output logic [NBR_N-1:0]        nbr_in_take,
   input  logic [DATA_W-1:0]       rtr_in_data,
   input  logic                    rtr_in_valid,
   output logic                    rtr_in_take,
   output logic                    busy,
   output logic [DATA_W-1:0]       nbr_out_data,
   output logic [NBR_N-1:0]        nbr_out_valid,
   output logic [DATA_W-1:0]       rtr_out_data,
   output logic                    rtr_out_valid,
   output logic [TGT_W-1:0]        rtr_out_target,
   output logic [DATA_W-1:0]       fin_data,
   output logic                    fin_valid
);

   localparam int NOPND = 2;

   if (DATA_W < 2 || DATA_W > IMM_W) begin : g_bad_width
      $error("coarse_pe: DATA_W must lie in 2..IMM_W");
   end
   if (NBR_N < 1 || NBR_N + 1 >= (1 << SEL_W)) begin : g_bad_nbr
      $error("coarse_pe: NBR_N does not fit the source select code space");
   end
   if (NBR_N > (1 << TGT_W)) begin : g_bad_tgt
      $error("coarse_pe: NBR_N exceeds the slot target range");
   end

   cfg_t cfg_q;
   logic armed, load, fire, alu_busy, alu_done;
   logic [DATA_W-1:0] alu_res;

   logic [SEL_W-1:0]  sel      [NOPND];
   logic [DATA_W-1:0] imm      [NOPND];
   logic [DATA_W-1:0] opnd     [NOPND];
   logic              rdy      [NOPND];
   logic [NBR_N-1:0]  nbr_need [NOPND];
   logic              rtr_need [NOPND];

   assign sel[0] = cfg_q.sel_a;
   assign sel[1] = cfg_q.sel_b;
   assign imm[0] = cfg_q.imm_a[DATA_W-1:0];
   assign imm[1] = cfg_q.imm_b[DATA_W-1:0];

   logic [2*IMM_W+6:0] unused_bits;
   assign unused_bits = {cfg_q.imm_a, cfg_q.imm_b, cfg_q.rsvd};

   assign cfg_ready = !alu_busy;
   assign load      = cfg_valid && cfg_ready;
   assign fire      = armed && !load && !alu_busy && rdy[0] && rdy[1];
   assign busy      = alu_busy;

   coarse_pe_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .word_in (cfg_t'(cfg_word)),
      .fire    (fire),
      .word_q  (cfg_q),
      .armed   (armed)
   );

   for (genvar k = 0; k < NOPND; k++) begin : g_opnd
      coarse_pe_opnd_mux #(.DATA_W(DATA_W), .NBR_N(NBR_N)) u_mux (
         .sel       (sel[k]),
         .imm       (imm[k]),
         .nbr_data  (nbr_in_data),
         .nbr_valid (nbr_in_valid),
         .rtr_data  (rtr_in_data),
         .rtr_valid (rtr_in_valid),
         .opnd      (opnd[k]),
         .ready     (rdy[k]),
         .nbr_need  (nbr_need[k]),
         .rtr_need  (rtr_need[k])
      );
   end

   assign nbr_in_take = fire ? (nbr_need[0] | nbr_need[1]) : '0;
   assign rtr_in_take = fire && (rtr_need[0] || rtr_need[1]);

   coarse_pe_alu #(.DATA_W(DATA_W)) u_alu (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (fire),
      .opc    (cfg_q.opc),
      .a      (opnd[0]),
      .b      (opnd[1]),
      .busy   (alu_busy),
      .done   (alu_done),
      .result (alu_res)
   );

   coarse_pe_steer #(.DATA_W(DATA_W), .NBR_N(NBR_N)) u_steer (
      .done           (alu_done),
      .result         (alu_res),
      .act            (cfg_q.act),
      .dst            (cfg_q.dst),
      .nbr_out_data   (nbr_out_data),
      .nbr_out_valid  (nbr_out_valid),
      .rtr_out_data   (rtr_out_data),
      .rtr_out_valid  (rtr_out_valid),
      .rtr_out_target (rtr_out_target),
      .fin_data       (fin_data),
      .fin_valid      (fin_valid)
   );

endmodule

module coarse_pe_chk #(
   parameter int NBR_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_valid,
   input logic             cfg_ready,
   input logic [NBR_N-1:0] nbr_in_valid,
   input logic [NBR_N-1:0] nbr_in_take,
   input logic             rtr_in_valid,
   input logic             rtr_in_take,
   input logic             busy,
   input logic             fin_valid
);

   // R1
   cfg_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_ready) |=> !busy);

   // R5
   busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (nbr_in_take == '0 && !rtr_in_take));

   // R5
   result_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> !busy);

   // R6
   rtr_take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rtr_in_take |-> rtr_in_valid);

   // R6
   nbr_take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nbr_in_take & ~nbr_in_valid) == '0);

endmodule

bind coarse_pe coarse_pe_chk #(.NBR_N(NBR_N)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_valid    (cfg_valid),
   .cfg_ready    (cfg_ready),
   .nbr_in_valid (nbr_in_valid),
   .nbr_in_take  (nbr_in_take),
   .rtr_in_valid (rtr_in_valid),
   .rtr_in_take  (rtr_in_take),
   .busy         (busy),
   .fin_valid    (fin_valid)
);

// File: tb/coarse_pe_tb.sv
`timescale 1ns/1ps
module coarse_pe_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [95:0] cfg_word = '0;
   logic        cfg_ready;
   logic [63:0] nbr_in_data = '0;
   logic [3:0]  nbr_in_valid = '0;
   logic [3:0]  nbr_in_take;
   logic [15:0] rtr_in_data = '0;
   logic        rtr_in_valid = 1'b0;
   logic        rtr_in_take;
   logic        busy;
   logic [15:0] nbr_out_data;
   logic [3:0]  nbr_out_valid;
   logic [15:0] rtr_out_data;
   logic        rtr_out_valid;
   logic [6:0]  rtr_out_target;
   logic [15:0] fin_data;
   logic        fin_valid;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   coarse_pe u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
      .cfg_ready(cfg_ready), .nbr_in_data(nbr_in_data), .nbr_in_valid(nbr_in_valid),
      .nbr_in_take(nbr_in_take), .rtr_in_data(rtr_in_data), .rtr_in_valid(rtr_in_valid),
      .rtr_in_take(rtr_in_take), .busy(busy), .nbr_out_data(nbr_out_data),
      .nbr_out_valid(nbr_out_valid), .rtr_out_data(rtr_out_data),
      .rtr_out_valid(rtr_out_valid), .rtr_out_target(rtr_out_target),
      .fin_data(fin_data), .fin_valid(fin_valid)
   );

   // {opcode, A, B, expected}
   localparam logic [51:0] VEC [12] = '{
      {4'd0, 16'h1234, 16'h0FFF, 16'h2233},
      {4'd1, 16'h0005, 16'h0007, 16'hFFFE},
      {4'd2, 16'h0123, 16'h0100, 16'h2300},
      {4'd3, 16'h1000, 16'h0007, 16'h0249},
      {4'd4, 16'hBEEF, 16'h1111, 16'hBEEF},
      {4'd5, 16'hF0F0, 16'h3C3C, 16'h3030},
      {4'd6, 16'hF0F0, 16'h0F01, 16'hFFF1},
      {4'd7, 16'hAAAA, 16'hFFFF, 16'h5555},
      {4'd3, 16'h1234, 16'h0000, 16'hFFFF},
      {4'd9, 16'h0042, 16'h9999, 16'h0042},
      {4'd0, 16'hFFFF, 16'h0002, 16'h0001},
      {4'd3, 16'h00FF, 16'h0100, 16'h0000}
   };

   function automatic logic [95:0] mk(input logic [15:0] a, input logic [15:0] b,
                                      input logic [3:0] sa, input logic [3:0] sb,
                                      input logic [3:0] op, input logic [39:0] dst,
                                      input logic [3:0] act, input logic rpt);
      return {a, b, sa, sb, op, dst, act, rpt, 7'h0};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_cfg(input logic [95:0] w);
      @(negedge clk);
      cfg_word  = w;
      cfg_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cfg_valid = 1'b0;
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   bit finished = 0;

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int lat;
      int seen;
      int extra;
      logic [39:0] dst;

      // R10: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 fin_valid", fin_valid, 0);
      chk("R10 rtr_out_valid", rtr_out_valid, 0);
      chk("R10 nbr_out_valid", nbr_out_valid, 0);
      chk("R10 busy", busy, 0);
      chk("R10 cfg_ready", cfg_ready, 1);
      rst_n = 1'b1;
      step();
      step();
      chk("R10 nothing armed", fin_valid, 0);

      // R3 R4 R5 R9: table walk, immediate operands, one-shot, final action
      for (int i = 0; i < 12; i++) begin
         do_cfg(mk(VEC[i][35:20], VEC[i][19:4] == 0 ? 16'h0 : VEC[i][35:20], 4'd0, 4'd0,
                   VEC[i][51:48], 40'h0, 4'd0, 1'b0) & 96'h0 |
                mk(VEC[i][47:32], VEC[i][31:16], 4'd0, 4'd0, VEC[i][51:48], 40'h0, 4'd0, 1'b0));
         lat  = 0;
         seen = 0;
         while (lat < 40 && seen == 0) begin
            step();
            lat++;
            if (fin_valid) seen = 1;
         end
         chk($sformatf("R3 result vec%0d", i), fin_data, VEC[i][15:0]);
         if (VEC[i][51:48] == 4'd3)
            chk($sformatf("R5 divide latency vec%0d", i), lat, 17);
         else
            chk($sformatf("R4 latency vec%0d", i), lat, 1);
         extra = 0;
         for (int c = 0; c < 3; c++) begin
            step();
            if (fin_valid) extra++;
         end
         chk($sformatf("R9 single shot vec%0d", i), extra, 0);
      end

      // R1 R5: configuration offered during divide is dropped
      do_cfg(mk(16'h0100, 16'h0003, 4'd0, 4'd0, 4'd3, 40'h0, 4'd0, 1'b0));
      step();
      chk("R5 busy during divide", busy, 1);
      chk("R1 cfg_ready low during divide", cfg_ready, 0);
      cfg_word  = mk(16'h0001, 16'h0001, 4'd0, 4'd0, 4'd0, 40'h0, 4'd0, 1'b1);
      cfg_valid = 1'b1;
      step();
      cfg_valid = 1'b0;
      seen = 0;
      lat  = 0;
      while (lat < 40 && seen == 0) begin
         step();
         lat++;
         if (fin_valid) seen = 1;
      end
      chk("R5 quotient 256/3", fin_data, 16'h0055);
      chk("R5 busy cleared", busy, 0);
      extra = 0;
      for (int c = 0; c < 5; c++) begin
         step();
         if (fin_valid) extra++;
      end
      chk("R1 dropped word never fires", extra, 0);

      // R2 R6: neighbour and router operand sources
      do_cfg(mk(16'h0, 16'h0, 4'd2, 4'd5, 4'd0, 40'h0, 4'd0, 1'b0));
      extra = 0;
      for (int c = 0; c < 3; c++) begin
         step();
         if (fin_valid || nbr_in_take != 0 || rtr_in_take) extra++;
      end
      chk("R6 waits for valid sources", extra, 0);
      nbr_in_data  = {16'h0, 16'h0, 16'h0100, 16'h7777};
      nbr_in_valid = 4'b0011;
      rtr_in_data  = 16'h0023;
      rtr_in_valid = 1'b1;
      #1;
      chk("R6 nbr take link1", nbr_in_take, 4'b0010);
      chk("R6 router take", rtr_in_take, 1);
      step();
      nbr_in_valid = '0;
      rtr_in_valid = 1'b0;
      chk("R2 neighbour+router sum", {fin_valid, fin_data}, {1'b1, 16'h0123});

      // R9: continuous repeat on router operands
      do_cfg(mk(16'h0, 16'h0001, 4'd5, 4'd0, 4'd0, 40'h0, 4'd0, 1'b1));
      rtr_in_valid = 1'b1;
      rtr_in_data  = 16'd10;
      step();
      chk("R9 repeat first", {fin_valid, fin_data}, {1'b1, 16'd11});
      rtr_in_data = 16'd20;
      step();
      chk("R9 repeat second", {fin_valid, fin_data}, {1'b1, 16'd21});
      rtr_in_valid = 1'b0;
      step();
      chk("R9 idle without operand", fin_valid, 0);
      step();
      rtr_in_valid = 1'b1;
      rtr_in_data  = 16'd40;
      step();
      rtr_in_valid = 1'b0;
      chk("R9 still armed", {fin_valid, fin_data}, {1'b1, 16'd41});

      // R7 R8: destination steering
      dst = {1'b1, 2'd2, 7'd0,  1'b1, 2'd1, 7'h11,  1'b1, 2'd1, 7'h55,  1'b1, 2'd0, 7'd2};
      do_cfg(mk(16'h0003, 16'h0004, 4'd0, 4'd0, 4'd2, dst, 4'd1, 1'b0));
      step();
      chk("R8 nbr link 2", nbr_out_valid, 4'b0100);
      chk("R8 nbr data", nbr_out_data, 16'h000C);
      chk("R8 router valid", rtr_out_valid, 1);
      chk("R8 router target lowest slot", rtr_out_target, 7'h55);
      chk("R8 router data", rtr_out_data, 16'h000C);
      chk("R8 final slot", {fin_valid, fin_data}, {1'b1, 16'h000C});

      do_cfg(mk(16'h0005, 16'h0003, 4'd0, 4'd0, 4'd7, dst, 4'd0, 1'b0));
      step();
      chk("R7 final action ignores slots", {fin_valid, rtr_out_valid, nbr_out_valid},
          {1'b1, 1'b0, 4'b0000});
      chk("R7 final data", fin_data, 16'h0006);

      do_cfg(mk(16'h0005, 16'h0003, 4'd0, 4'd0, 4'd7, dst, 4'd2, 1'b0));
      step();
      chk("R7 discard action", {fin_valid, rtr_out_valid, nbr_out_valid}, 6'b0);

      dst = {1'b1, 2'd3, 7'd1,  1'b1, 2'd0, 7'd9,  10'h0,  10'h0};
      do_cfg(mk(16'h0005, 16'h0003, 4'd0, 4'd0, 4'd0, dst, 4'd1, 1'b0));
      step();
      chk("R8 ignored kind and range", {fin_valid, rtr_out_valid, nbr_out_valid}, 6'b0);

      summary();
   end

endmodule